// File: doc/BRIEF.md
# Stack and Interrupt Control Sequencer

This block is the multi-cycle control sequencer that runs the stack-related, flag-related and interrupt-related instructions of a 16-bit processor. It owns the program counter, the stack pointer, the flag register, and a saved-vector register. The interrupt-enable bit is one bit of the flag register, so it is saved and restored along with the other flags. Arithmetic and branch conditions are handled elsewhere.

Every instruction starts with one fetch cycle. That cycle reads the word at the program counter and advances the counter. In the next cycle, an external decoder turns the fetched word into an opcode, register fields and an illegal-opcode strobe. The sequencer then runs the steps for that opcode against a synchronous, word-addressed memory port, where read data arrives one cycle after its address. It also uses a register-file port with combinational read and clocked write.

A hardware interrupt is taken only in the fetch slot, and only while interrupts are enabled. An illegal opcode is discovered only after it has been fetched. The block then redirects execution to a fixed vector and records the address of the bad opcode.

Top module: `stk_irq_seq`

## Requirements
- R1: While reset is held the block shows PC 0x0000, SP 0xFFFF, flags 0x0000 (interrupts disabled), saved vector 0x0010, busy high and no memory write.
- R2: Each instruction begins with a cycle that presents PC on the memory address and advances PC by one. The following cycle consumes the fetched word as opcode (bits 3:0), illegal strobe (bit 15), register field dr (bits 9:4) and address-register field ar (bits 12:10).
- R3: Push-type steps write at the current SP and then decrement SP. Pop-type steps first increment SP and then read the word at the new SP.
- R4: Opcode 1 (call) pushes the address just past its operand word, then loads PC from the operand word. It takes 4 cycles.
- R5: Opcode 2 (indirect call) pushes the address of the next instruction and loads PC from register number ar+56. It takes 2 cycles.
- R6: Opcode 3 (return) pops PC in 4 cycles. Opcode 4 (return from interrupt) does the same and also clears the interrupt-enable bit.
- R7: Opcode 5 pushes the flag register in 2 cycles. Opcode 6 pops the flag register in 4 cycles.
- R8: Opcode 7 pushes register dr in 2 cycles. Opcode 8 pops the top of stack into register dr in 4 cycles.
- R9: Opcode 9 (software interrupt) pushes the next-instruction address, loads PC from the saved-vector register and leaves the flags unchanged. It takes 2 cycles.
- R10: A fetched word with the illegal strobe set loads PC with 0x0002 and stores the opcode's own address (PC−1) into the saved-vector register. It writes no memory and leaves SP unchanged. It takes 2 cycles.
- R11: A hardware interrupt request is taken in the fetch slot only while flag bit 15 (interrupt enable) is set. When taken, in a single cycle it pushes PC, loads PC from the saved-vector register and clears bit 15. While bit 15 is clear the request has no effect.
- R12: Busy is low in exactly the final cycle of each sequence and high in every other cycle of it.
- R13: Opcodes 0 and 10 to 15 complete in 2 cycles with no effect other than the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq | input | 1 | Hardware interrupt request (level) |
| dec_op | input | 4 | Decoded opcode of the fetched word |
| dec_illegal | input | 1 | Fetched word is not a legal opcode |
| dec_dr | input | 6 | Data-register field of the fetched word |
| dec_ar | input | 3 | Address-register field of the fetched word |
| mem_rdata | input | 16 | Memory read data, one cycle after address |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| rf_rdata | input | 16 | Register-file read data for rf_raddr |
| rf_raddr | output | 6 | Register-file read index |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 6 | Register-file write index |
| rf_wdata | output | 16 | Register-file write data |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| flags | output | 16 | Flag register, bit 15 is interrupt enable |
| ivec | output | 16 | Saved-vector register |
| busy | output | 1 | Sequence in progress, low in its last cycle |

## Verification
The assertions check several rules on every cycle. Every memory write goes to the stack pointer. SP moves by at most one per cycle. A fetch slot always advances PC by one. An accepted interrupt clears the enable bit and is never taken while it is clear. The exception path always lands on vector 0x0002 with the bad opcode's address saved. Each low busy is followed by a fresh fetch. The bench scenarios are what show the stack contents, the return addresses, the order of nested call and interrupt frames, the flag round trip through the stack, and the cycle count of each opcode.

// File: rtl/stk_seq_pkg.sv
// Package: shared types for the stack and interrupt sequencer.
// Assumes: opcode codes are fixed by the external decoder contract.
package stk_seq_pkg;

    typedef enum logic [1:0] {ST_FETCH, ST_DEC, ST_EX1, ST_EX2} st_e;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_CALL  = 4'd1,
        OP_ICALL = 4'd2,
        OP_RET   = 4'd3,
        OP_RETI  = 4'd4,
        OP_PSHF  = 4'd5,
        OP_POPF  = 4'd6,
        OP_PUSH  = 4'd7,
        OP_POP   = 4'd8,
        OP_INT   = 4'd9
    } op_e;

    typedef enum logic {AS_PC, AS_SP} asel_e;
    typedef enum logic [1:0] {WS_PC, WS_PC1, WS_FR, WS_RF} wsel_e;
    typedef enum logic [2:0] {PL_HOLD, PL_INC, PL_RD, PL_RF, PL_IV, PL_EXC} psel_e;

    typedef struct packed {
        asel_e asel;     // memory address source
        logic  mem_we;   // memory write strobe
        wsel_e wsel;     // memory write data source
        logic  sp_inc;   // pre-increment for pops
        logic  sp_dec;   // post-decrement for pushes
        psel_e psel;     // program counter update source
        logic  fr_ld;    // load flags from memory data
        logic  ie_clr;   // clear interrupt enable
        logic  iv_save;  // save faulting address
        logic  rf_rd_ar; // read index from ar field (else dr)
        logic  rf_we;    // register write from memory data
        logic  lat;      // capture register fields
        logic  busy;     // sequence still running
    } ctl_t;

endpackage

// File: rtl/seq_sp_reg.sv
// Stack pointer register: +1 for pops, -1 for pushes.
// Assumes: the controller never asks for both directions at once.
module seq_sp_reg #(
    parameter int          DW       = 16,
    parameter logic [DW-1:0] SP_RESET = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [DW-1:0] sp
);

    logic [DW-1:0] sp_q;

    // Step the stack pointer by one in the requested direction.
    always_ff @(posedge clk) begin
        if (!rst_n)   sp_q <= SP_RESET;
        else if (inc) sp_q <= sp_q + DW'(1);
        else if (dec) sp_q <= sp_q - DW'(1);
    end

    assign sp = sp_q;

    // R3: the pointer only ever moves one word at a time
    a_r3_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_q == $past(sp_q)) || (sp_q == $past(sp_q) + DW'(1)) ||
        (sp_q == $past(sp_q) - DW'(1)));

    // R3: a single step never goes both ways
    a_r3_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && dec));

endmodule

// File: rtl/seq_ctrl.sv
// Sequencer FSM: fetch slot, decode/dispatch, then up to two execute steps.
// Assumes: decoder outputs are valid in the decode cycle only.
module seq_ctrl
    import stk_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_ok,
    input  logic [3:0] dec_op,
    input  logic       dec_illegal,
    output ctl_t       ctl
);

    st_e state_q, state_d;
    op_e op_q;

    // Advance the state and keep the opcode for the execute steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            op_q    <= OP_NOP;
        end else begin
            state_q <= state_d;
            if (state_q == ST_DEC) op_q <= op_e'(dec_op);
        end
    end

    // Produce this cycle's control word and the next state.
    always_comb begin
        ctl     = '0;
        state_d = state_q;
        case (state_q)
            ST_FETCH: begin
                if (irq_ok) begin
                    ctl.asel = AS_SP; ctl.mem_we = 1'b1; ctl.wsel = WS_PC;
                    ctl.sp_dec = 1'b1; ctl.psel = PL_IV; ctl.ie_clr = 1'b1;
                end else begin
                    ctl.psel = PL_INC; ctl.busy = 1'b1;
                    state_d  = ST_DEC;
                end
            end
            ST_DEC: begin
                ctl.lat = 1'b1;
                state_d = ST_FETCH;
                if (dec_illegal) begin
                    ctl.psel = PL_EXC; ctl.iv_save = 1'b1;
                end else begin
                    case (op_e'(dec_op))
                        OP_CALL: begin
                            ctl.asel = AS_SP; ctl.mem_we = 1'b1; ctl.wsel = WS_PC1;
                            ctl.sp_dec = 1'b1; ctl.busy = 1'b1; state_d = ST_EX1;
                        end
                        OP_ICALL: begin
                            ctl.asel = AS_SP; ctl.mem_we = 1'b1; ctl.wsel = WS_PC;
                            ctl.sp_dec = 1'b1; ctl.psel = PL_RF; ctl.rf_rd_ar = 1'b1;
                        end
                        OP_RET, OP_RETI, OP_POPF, OP_POP: begin
                            ctl.sp_inc = 1'b1; ctl.busy = 1'b1; state_d = ST_EX1;
                        end
                        OP_PSHF: begin
                            ctl.asel = AS_SP; ctl.mem_we = 1'b1; ctl.wsel = WS_FR;
                            ctl.sp_dec = 1'b1;
                        end
                        OP_PUSH: begin
                            ctl.asel = AS_SP; ctl.mem_we = 1'b1; ctl.wsel = WS_RF;
                            ctl.sp_dec = 1'b1;
                        end
                        OP_INT: begin
                            ctl.asel = AS_SP; ctl.mem_we = 1'b1; ctl.wsel = WS_PC;
                            ctl.sp_dec = 1'b1; ctl.psel = PL_IV;
                        end
                        default: ;
                    endcase
                end
            end
            ST_EX1: begin
                ctl.asel = (op_q == OP_CALL) ? AS_PC : AS_SP;
                ctl.busy = 1'b1;
                state_d  = ST_EX2;
            end
            default: begin
                state_d = ST_FETCH;
                case (op_q)
                    OP_CALL, OP_RET: ctl.psel = PL_RD;
                    OP_RETI: begin ctl.psel = PL_RD; ctl.ie_clr = 1'b1; end
                    OP_POPF: ctl.fr_ld = 1'b1;
                    OP_POP:  ctl.rf_we = 1'b1;
                    default: ;
                endcase
            end
        endcase
    end

    // R12: a finished sequence is always followed by a fresh fetch slot
    a_r12_busy_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.busy |=> (state_q == ST_FETCH));

    // R11: the fetch slot writes memory only for an accepted interrupt
    a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && ctl.mem_we) |-> irq_ok);

endmodule

// File: rtl/stk_irq_seq.sv
// Top: PC, flags and saved-vector registers plus memory/register-file muxes.
// Assumes: synchronous memory (data one cycle after address), combinational
// register-file read, and decoder outputs derived from mem_rdata.
module stk_irq_seq
    import stk_seq_pkg::*;
#(
    parameter int            DW       = 16,
    parameter int            RW       = 6,
    parameter int            AW       = 3,
    parameter int            AR_BASE  = 56,
    parameter int            IE_BIT   = 15,
    parameter logic [DW-1:0] PC_RESET = 16'h0000,
    parameter logic [DW-1:0] SP_RESET = 16'hFFFF,
    parameter logic [DW-1:0] IV_RESET = 16'h0010,
    parameter logic [DW-1:0] EXC_VEC  = 16'h0002
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq,
    input  logic [3:0]    dec_op,
    input  logic          dec_illegal,
    input  logic [RW-1:0] dec_dr,
    input  logic [AW-1:0] dec_ar,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] rf_rdata,
    output logic [RW-1:0] rf_raddr,
    output logic          rf_we,
    output logic [RW-1:0] rf_waddr,
    output logic [DW-1:0] rf_wdata,
    output logic [DW-1:0] pc,
    output logic [DW-1:0] sp,
    output logic [DW-1:0] flags,
    output logic [DW-1:0] ivec,
    output logic          busy
);

    localparam logic [RW-1:0] AR_OFS = RW'(AR_BASE);

    ctl_t          ctl;
    logic [DW-1:0] pc_q, fr_q, iv_q;
    logic [RW-1:0] dr_q;

    seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_ok      (irq && fr_q[IE_BIT]),
        .dec_op      (dec_op),
        .dec_illegal (dec_illegal),
        .ctl         (ctl)
    );

    seq_sp_reg #(.DW(DW), .SP_RESET(SP_RESET)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ctl.sp_inc),
        .dec   (ctl.sp_dec),
        .sp    (sp)
    );

    // Select memory address and write data for the current step.
    always_comb begin
        mem_addr = (ctl.asel == AS_SP) ? sp : pc_q;
        case (ctl.wsel)
            WS_PC:   mem_wdata = pc_q;
            WS_PC1:  mem_wdata = pc_q + DW'(1);
            WS_FR:   mem_wdata = fr_q;
            default: mem_wdata = rf_rdata;
        endcase
    end

    assign mem_we   = ctl.mem_we;
    assign rf_raddr = ctl.rf_rd_ar ? (AR_OFS + RW'(dec_ar)) : dec_dr;
    assign rf_we    = ctl.rf_we;
    assign rf_waddr = dr_q;
    assign rf_wdata = mem_rdata;

    // Update the program counter from the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= PC_RESET;
        else begin
            case (ctl.psel)
                PL_INC:  pc_q <= pc_q + DW'(1);
                PL_RD:   pc_q <= mem_rdata;
                PL_RF:   pc_q <= rf_rdata;
                PL_IV:   pc_q <= iv_q;
                PL_EXC:  pc_q <= EXC_VEC;
                default: ;
            endcase
        end
    end

    // Load flags from the stack or drop the interrupt-enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          fr_q <= '0;
        else if (ctl.fr_ld)  fr_q <= mem_rdata;
        else if (ctl.ie_clr) fr_q[IE_BIT] <= 1'b0;
    end

    // Record the faulting opcode address and the pop destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iv_q <= IV_RESET;
            dr_q <= '0;
        end else begin
            if (ctl.iv_save) iv_q <= pc_q - DW'(1);
            if (ctl.lat)     dr_q <= dec_dr;
        end
    end

    assign pc    = pc_q;
    assign flags = fr_q;
    assign ivec  = iv_q;
    assign busy  = ctl.busy;

    // R3: every memory write lands on the stack pointer
    a_r3_write_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == sp));

    // R2: a fetch slot advances PC by exactly one
    a_r2_fetch_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.psel == PL_INC) |=> (pc_q == $past(pc_q) + DW'(1)));

    // R10: exception lands on the fixed vector and saves the opcode address
    a_r10_exc_vec: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.iv_save |=> (pc_q == EXC_VEC) && (iv_q == $past(pc_q) - DW'(1)));

    // R11: accepting a hardware interrupt leaves interrupts disabled
    a_r11_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.psel == PL_IV && ctl.ie_clr) |=> !fr_q[IE_BIT]);

endmodule

// File: tb/test_stk_irq_seq.sv
module test_stk_irq_seq;

    typedef struct packed {
        logic [15:0] addr;
        logic [15:0] word;
        logic [15:0] pc;
        logic [15:0] sp;
        logic [15:0] fr;
        logic [3:0]  cyc;
    } row_t;

    // Program walked in order; expectations hold after each instruction.
    localparam row_t ROWS [12] = '{
        '{16'h0000, 16'h0057, 16'h0001, 16'hFFFE, 16'h0000, 4'd2}, // R8 push r5
        '{16'h0001, 16'h0006, 16'h0002, 16'hFFFF, 16'h8003, 4'd4}, // R7 popf
        '{16'h0002, 16'h0005, 16'h0003, 16'hFFFE, 16'h8003, 4'd2}, // R7 pshf
        '{16'h0003, 16'h0001, 16'h0020, 16'hFFFD, 16'h8003, 4'd4}, // R4 call
        '{16'h0020, 16'h0009, 16'h0010, 16'hFFFC, 16'h8003, 4'd2}, // R9 int
        '{16'h0010, 16'h0004, 16'h0021, 16'hFFFD, 16'h0003, 4'd4}, // R6 reti
        '{16'h0021, 16'h0C02, 16'h0030, 16'hFFFC, 16'h0003, 4'd2}, // R5 icall ar=3
        '{16'h0030, 16'h0098, 16'h0031, 16'hFFFD, 16'h0003, 4'd4}, // R8 pop r9
        '{16'h0031, 16'h000C, 16'h0032, 16'hFFFD, 16'h0003, 4'd2}, // R13 op 12
        '{16'h0032, 16'h0003, 16'h0005, 16'hFFFE, 16'h0003, 4'd4}, // R6 ret
        '{16'h0005, 16'h0006, 16'h0006, 16'hFFFF, 16'h8003, 4'd4}, // R7 popf
        '{16'h0006, 16'h0000, 16'h0007, 16'hFFFF, 16'h8003, 4'd2}  // R13 nop
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem_addr, mem_wdata, rf_rdata, rf_wdata;
    logic [15:0] pc, sp, flags, ivec;
    logic        mem_we, rf_we, busy;
    logic [5:0]  rf_raddr, rf_waddr;
    logic [15:0] mem [256];
    logic [15:0] rf [64];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    // Synchronous memory and register-file models.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
        if (rf_we) rf[rf_waddr] <= rf_wdata;
    end
    assign rf_rdata = rf[rf_raddr];

    stk_irq_seq i_stk_irq_seq (
        .clk(clk), .rst_n(rst_n), .irq(irq),
        .dec_op(mem_rdata[3:0]), .dec_illegal(mem_rdata[15]),
        .dec_dr(mem_rdata[9:4]), .dec_ar(mem_rdata[12:10]),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .rf_rdata(rf_rdata), .rf_raddr(rf_raddr),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .pc(pc), .sp(sp), .flags(flags), .ivec(ivec), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Called in an instruction's first cycle; returns at the next one.
    task automatic run_instr(output int n);
        n = 1;
        while (busy) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            summary();
        end
    end

    initial begin
        int n;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 64; i++) rf[i] = '0;
        rf[5]  = 16'h8003;
        rf[59] = 16'h0030;
        for (int i = 0; i < 12; i++) mem[ROWS[i].addr[7:0]] = ROWS[i].word;
        mem[4] = 16'h0020;   // call operand
        mem[8] = 16'h8000;   // illegal word after the nop at 7

        repeat (3) @(negedge clk);
        chk(pc == 16'h0000,    "R1 pc",    pc, 16'h0000);
        chk(sp == 16'hFFFF,    "R1 sp",    sp, 16'hFFFF);
        chk(flags == 16'h0000, "R1 flags", flags, 16'h0000);
        chk(ivec == 16'h0010,  "R1 ivec",  ivec, 16'h0010);
        chk(busy && !mem_we,   "R1 busy/we", {busy, mem_we}, 2'b10);
        rst_n = 1'b1;

        // R2: first cycle after reset presents PC on the address
        chk(mem_addr == 16'h0000 && busy, "R2 fetch addr", mem_addr, 16'h0000);

        foreach (ROWS[i]) begin
            run_instr(n);
            chk(pc == ROWS[i].pc,    "R2 R4 R5 R6 pc",   pc, ROWS[i].pc);
            chk(sp == ROWS[i].sp,    "R3 sp",            sp, ROWS[i].sp);
            chk(flags == ROWS[i].fr, "R6 R7 R9 flags",   flags, ROWS[i].fr);
            chk(n == int'(ROWS[i].cyc), "R12 cycles",    n, ROWS[i].cyc);
        end

        // R4: return address pushed by call skips its operand word
        chk(mem[8'hFE] == 16'h0005, "R4 stacked ret", mem[8'hFE], 16'h0005);
        // R8/R5: pop into r9 received the icall return address
        chk(rf[9] == 16'h0022, "R8 pop r9", rf[9], 16'h0022);

        // R11: interrupt accepted in the fetch slot while enabled
        irq = 1'b1;
        #1;
        chk(!busy && mem_we && mem_addr == 16'hFFFF, "R11 take",
            {busy, mem_we}, 2'b01);
        @(negedge clk);
        irq = 1'b0;
        chk(pc == 16'h0010, "R11 pc", pc, 16'h0010);
        chk(sp == 16'hFFFE, "R11 sp", sp, 16'hFFFE);
        chk(flags == 16'h0003, "R11 ie clr", flags, 16'h0003);
        chk(mem[8'hFF] == 16'h0007, "R11 pushed pc", mem[8'hFF], 16'h0007);

        // R11: request held while disabled has no effect
        irq = 1'b1;
        #1;
        chk(busy && !mem_we, "R11 masked slot", {busy, mem_we}, 2'b10);
        run_instr(n);    // reti at 0x10
        chk(pc == 16'h0007 && sp == 16'hFFFF, "R6 R11 reti masked", pc, 16'h0007);
        chk(n == 4, "R12 reti cycles", n, 4);
        run_instr(n);    // nop at 7, irq still high but disabled
        irq = 1'b0;
        chk(pc == 16'h0008 && sp == 16'hFFFF, "R11 R13 ignored", pc, 16'h0008);

        // R10: illegal opcode at 8
        run_instr(n);
        chk(pc == 16'h0002, "R10 pc", pc, 16'h0002);
        chk(ivec == 16'h0008, "R10 ivec", ivec, 16'h0008);
        chk(sp == 16'hFFFF, "R10 sp", sp, 16'hFFFF);
        chk(mem[8'hFF] == 16'h0007, "R10 no write", mem[8'hFF], 16'h0007);
        chk(n == 2, "R12 illegal cycles", n, 2);

        done = 1'b1;
        summary();
    end

endmodule